// File: doc/BRIEF.md
# I2C EEPROM Slave Protocol Engine

This block is the serial front end of a 256-byte EEPROM. It watches an oversampled two-wire bus (clock and data lines sampled on the system clock) and drives the data line through an open-drain enable. It recognises START and STOP conditions and answers only to the fixed 7-bit device identity. It carries out byte writes, page writes, reads from the current address, reads from a given address and sequential reads. On the memory side it steers a page buffer with four single-cycle commands: load the word address, store a data byte, commit the buffered page, and discard the buffered page. A combinational read port fetches array bytes at the engine's internal address.

Two behaviours let a bus master manage the slow nonvolatile write without timers. While the array reports that an internal write is running, the engine withholds the acknowledge even from its own address, so the master can poll until it gets one. A write-protect input is captured once per write sequence, at the falling clock edge that closes the word-address acknowledge. When it is high, the first data byte is refused and the buffered page is dropped.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: A high-to-low data transition while the clock is high is a START, and a low-to-high one is a STOP. Without a preceding START the engine never drives the data line and issues no page-buffer command. After reset the data line is released.
- R2: The byte after START is the device byte: bits 7..1 must equal DEV_ID (default 7'b1010000) and bit 0 selects read (1) or write (0). Any other value gets no acknowledge, and the bus is ignored until the next START.
- R3: Received bits are taken on the rising clock edge. The data-line enable changes only after a falling clock edge or a START/STOP, so the slave never moves the line while the clock is high. A 1 is sent by releasing the line.
- R4: Every accepted byte is acknowledged by pulling the data line low for the whole ninth clock. The line is released at the falling edge that ends it.
- R5: While wr_busy_i is high at the end of the device byte, that byte gets no acknowledge even when it matches, and the sequence is dropped.
- R6: In a write, the word-address byte produces one pb_load_o pulse with mem_addr_o holding that address. Each acknowledged data byte produces one pb_strobe_o pulse with the byte on pb_data_o. A STOP after at least one stored byte produces one pb_commit_o pulse.
- R7: wp_i is captured at the falling edge that ends the word-address acknowledge. If it is high, the first data byte gets no acknowledge, no strobe is issued, pb_abort_o pulses and nothing is committed. A change of wp_i after the first data byte was accepted has no effect on that sequence.
- R8: The internal address is set by the word-address byte and advances by one for each byte sent in a read. A read with no word address starts from it. Writes do not advance it.
- R9: A word-address write followed by a repeated START and a read-mode device byte returns the byte at that word address.
- R10: During a read, an acknowledge from the master makes the engine send the next byte. A missing acknowledge ends the read and releases the line. The address wraps from 255 to 0.
- R11: A START in any state restarts device-byte reception and releases the line. If data bytes were stored and not committed, it pulses pb_abort_o instead of committing. A STOP in the middle of a byte returns the engine to idle.
- R12: At most one of pb_load_o, pb_strobe_o, pb_commit_o and pb_abort_o is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls the data line low (open drain) |
| wp_i | input | 1 | Write protect, 1 blocks writes |
| wr_busy_i | input | 1 | Internal nonvolatile write in progress |
| mem_addr_o | output | 8 | Internal address: read-port address and page-load address |
| rd_data_i | input | 8 | Array byte at mem_addr_o |
| pb_data_o | output | 8 | Data byte for the page buffer |
| pb_load_o | output | 1 | Pulse: latch mem_addr_o as page start |
| pb_strobe_o | output | 1 | Pulse: store pb_data_o in the page buffer |
| pb_commit_o | output | 1 | Pulse: start the internal write of the buffered page |
| pb_abort_o | output | 1 | Pulse: discard the buffered page |

## Verification
The bench builds the engine with its defaults: two synchroniser stages and DEV_ID 7'b1010000, with the 8-bit address space fixed by the single word-address byte. The 256-byte space makes the 255-to-0 read wrap reachable with a few bytes of sequential read. A 600-cycle busy window in the bench's array model outlasts several bus bytes, so acknowledge polling is observed to be refused before it is granted. Sixteen-byte page readbacks after random page writes of up to twenty bytes show in-page overwrite through the buffer commands.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADDR,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_MACK
  } state_e;
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q, scl_s, sda_s;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        scl_ff[g] <= 1'b1;
        sda_ff[g] <= 1'b1;
      end else if (g == 0) begin
        scl_ff[g] <= scl_i;
        sda_ff[g] <= sda_i;
      end else begin
        scl_ff[g] <= scl_ff[(g == 0) ? 0 : g-1];
        sda_ff[g] <= sda_ff[(g == 0) ? 0 : g-1];
      end
    end
  end

  assign scl_s = scl_ff[STAGES-1];
  assign sda_s = sda_ff[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  // data edge while clock stays high
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_slv_fsm.sv
module i2c_slv_fsm
  import i2c_slv_pkg::*;
#(
  parameter logic [6:0] DEV_ID = 7'b1010000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              wr_busy_i,
  input  logic              wp_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              sda_oe_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic              load_o,
  output logic              strobe_o,
  output logic              commit_o,
  output logic              abort_o
);
  localparam logic [3:0] BITS = 4'(BYTE_W);

  state_e            st, nxt;
  logic [BYTE_W-1:0] sh;
  logic [3:0]        cnt;
  logic [ADDR_W-1:0] addr;
  logic              oe, wp_lat, wr_pend, mack;
  logic              dev_hit;

  assign dev_hit = (sh[BYTE_W-1:1] == DEV_ID);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st       <= ST_IDLE;
      nxt      <= ST_IDLE;
      sh       <= '0;
      cnt      <= '0;
      addr     <= '0;
      oe       <= 1'b0;
      wp_lat   <= 1'b0;
      wr_pend  <= 1'b0;
      mack     <= 1'b1;
      wdata_o  <= '0;
      load_o   <= 1'b0;
      strobe_o <= 1'b0;
      commit_o <= 1'b0;
      abort_o  <= 1'b0;
    end else begin
      load_o   <= 1'b0;
      strobe_o <= 1'b0;
      commit_o <= 1'b0;
      abort_o  <= 1'b0;
      if (start_i) begin
        st      <= ST_DEV;
        cnt     <= '0;
        oe      <= 1'b0;
        abort_o <= wr_pend;
        wr_pend <= 1'b0;
      end else if (stop_i) begin
        st       <= ST_IDLE;
        oe       <= 1'b0;
        commit_o <= wr_pend;
        wr_pend  <= 1'b0;
      end else begin
        unique case (st)
          ST_DEV, ST_WADDR, ST_WDATA: begin
            if (scl_rise_i && cnt != BITS) begin
              sh  <= {sh[BYTE_W-2:0], sda_s_i};
              cnt <= cnt + 4'd1;
            end else if (scl_fall_i && cnt == BITS) begin
              cnt <= '0;
              if (st == ST_DEV) begin
                if (dev_hit && !wr_busy_i) begin
                  oe  <= 1'b1;
                  st  <= ST_ACK;
                  nxt <= sh[0] ? ST_RDATA : ST_WADDR;
                end else begin
                  st <= ST_IDLE;
                end
              end else if (st == ST_WADDR) begin
                oe     <= 1'b1;
                st     <= ST_ACK;
                nxt    <= ST_WDATA;
                addr   <= sh;
                load_o <= 1'b1;
              end else if (wp_lat) begin
                // protected: refuse first data byte, drop the page
                st      <= ST_IDLE;
                abort_o <= 1'b1;
              end else begin
                oe       <= 1'b1;
                st       <= ST_ACK;
                nxt      <= ST_WDATA;
                wdata_o  <= sh;
                strobe_o <= 1'b1;
                wr_pend  <= 1'b1;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              st <= nxt;
              if (nxt == ST_RDATA) begin
                sh   <= rd_data_i;
                oe   <= ~rd_data_i[BYTE_W-1];
                addr <= addr + 1'b1;
                cnt  <= 4'd1;
              end else begin
                oe  <= 1'b0;
                cnt <= '0;
                if (nxt == ST_WDATA && !wr_pend) wp_lat <= wp_i;
              end
            end
          end
          ST_RDATA: begin
            if (scl_fall_i) begin
              if (cnt == BITS) begin
                oe <= 1'b0;
                st <= ST_MACK;
              end else begin
                oe  <= ~sh[BYTE_W-2];
                sh  <= {sh[BYTE_W-2:0], 1'b0};
                cnt <= cnt + 4'd1;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise_i) begin
              mack <= sda_s_i;
            end else if (scl_fall_i) begin
              if (!mack) begin
                st   <= ST_RDATA;
                sh   <= rd_data_i;
                oe   <= ~rd_data_i[BYTE_W-1];
                addr <= addr + 1'b1;
                cnt  <= 4'd1;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o = oe;
  assign addr_o   = addr;
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
  import i2c_slv_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ID      = 7'b1010000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic              wp_i,
  input  logic              wr_busy_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic [BYTE_W-1:0] pb_data_o,
  output logic              pb_load_o,
  output logic              pb_strobe_o,
  output logic              pb_commit_o,
  output logic              pb_abort_o
);
  logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;

  i2c_bus_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_ev),
    .stop_o     (stop_ev)
  );

  i2c_slv_fsm #(.DEV_ID(DEV_ID)) i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_s_i    (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_ev),
    .stop_i     (stop_ev),
    .wr_busy_i  (wr_busy_i),
    .wp_i       (wp_i),
    .rd_data_i  (rd_data_i),
    .sda_oe_o   (sda_oe_o),
    .addr_o     (mem_addr_o),
    .wdata_o    (pb_data_o),
    .load_o     (pb_load_o),
    .strobe_o   (pb_strobe_o),
    .commit_o   (pb_commit_o),
    .abort_o    (pb_abort_o)
  );
endmodule

// File: rtl/i2c_eeprom_slave_chk.sv
module i2c_eeprom_slave_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_fall,
  input logic start_ev,
  input logic stop_ev,
  input logic sda_oe_o,
  input logic pb_load_o,
  input logic pb_strobe_o,
  input logic pb_commit_o,
  input logic pb_abort_o
);
  p_oe_moves_on_fall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> $past(scl_fall || start_ev || stop_ev));

  p_release_on_cond_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_ev || stop_ev) |=> !sda_oe_o);

  p_commit_after_stop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pb_commit_o |-> $past(stop_ev));

  p_strobe_after_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pb_strobe_o |-> $past(scl_fall));

  p_load_after_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pb_load_o |-> $past(scl_fall));

  p_abort_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pb_abort_o |-> $past(start_ev || scl_fall));

  p_one_command_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pb_load_o, pb_strobe_o, pb_commit_o, pb_abort_o}));
endmodule

bind i2c_eeprom_slave i2c_eeprom_slave_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .scl_fall    (scl_fall),
  .start_ev    (start_ev),
  .stop_ev     (stop_ev),
  .sda_oe_o    (sda_oe_o),
  .pb_load_o   (pb_load_o),
  .pb_strobe_o (pb_strobe_o),
  .pb_commit_o (pb_commit_o),
  .pb_abort_o  (pb_abort_o)
);

// File: tb/test_i2c_eeprom_slave.sv
module test_i2c_eeprom_slave;
  localparam int CLK_P    = 10;
  localparam int QTR      = 4;
  localparam int BUSY_CYC = 600;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic sda_oe, sda_bus, wr_busy;
  logic [7:0] mem_addr, rd_data, pb_data;
  logic pb_load, pb_strobe, pb_commit, pb_abort;

  logic [7:0] mem [256];
  logic [7:0] ref_mem [256];
  logic [7:0] ref_addr;
  logic [7:0] wbuf [32];
  int busy_cnt = 0;

  assign sda_bus = sda_m & ~sda_oe;
  assign wr_busy = (busy_cnt != 0);
  assign rd_data = mem[mem_addr];

  i2c_eeprom_slave i_i2c_eeprom_slave (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .scl_i       (scl_m),
    .sda_i       (sda_bus),
    .sda_oe_o    (sda_oe),
    .wp_i        (wp),
    .wr_busy_i   (wr_busy),
    .mem_addr_o  (mem_addr),
    .rd_data_i   (rd_data),
    .pb_data_o   (pb_data),
    .pb_load_o   (pb_load),
    .pb_strobe_o (pb_strobe),
    .pb_commit_o (pb_commit),
    .pb_abort_o  (pb_abort)
  );

  // array + page buffer environment
  logic [7:0] pbase;
  logic [3:0] poff;
  logic [7:0] pbuf [16];
  logic       pvld [16];
  int n_load = 0, n_strobe = 0, n_commit = 0, n_abort = 0, n_overlap = 0, n_oe_bad = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
      if (int'(pb_load) + int'(pb_strobe) + int'(pb_commit) + int'(pb_abort) > 1)
        n_overlap <= n_overlap + 1;
      if (pb_load) begin
        pbase <= mem_addr;
        poff  <= 4'd0;
        for (int i = 0; i < 16; i++) pvld[i] <= 1'b0;
        n_load <= n_load + 1;
      end
      if (pb_strobe) begin
        pbuf[pbase[3:0] + poff] <= pb_data;
        pvld[pbase[3:0] + poff] <= 1'b1;
        poff <= poff + 4'd1;
        n_strobe <= n_strobe + 1;
      end
      if (pb_commit) begin
        for (int i = 0; i < 16; i++)
          if (pvld[i]) mem[{pbase[7:4], 4'(i)}] <= pbuf[i];
        for (int i = 0; i < 16; i++) pvld[i] <= 1'b0;
        busy_cnt <= BUSY_CYC;
        n_commit <= n_commit + 1;
      end
      if (pb_abort) begin
        for (int i = 0; i < 16; i++) pvld[i] <= 1'b0;
        n_abort <= n_abort + 1;
      end
    end
  end

  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (sda_oe !== oe_prev && scl_m) n_oe_bad++;
    oe_prev = sda_oe;
  end

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic q();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; q();
    scl_m = 1'b1; q();
    sda_m = 1'b0; q();
    scl_m = 1'b0; q();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; q();
    scl_m = 1'b1; q();
    sda_m = 1'b1; q();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; q();
    scl_m = 1'b1; q(); q();
    scl_m = 1'b0; q();
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; q();
    scl_m = 1'b1; q();
    ack = (sda_bus == 1'b0);
    q();
    scl_m = 1'b0; q();
  endtask

  task automatic rd_byte(input bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      q();
      scl_m = 1'b1; q();
      b = {b[6:0], sda_bus};
      q();
      scl_m = 1'b0; q();
    end
    send_bit(give_ack ? 1'b0 : 1'b1);
  endtask

  task automatic dev_open(input logic rd, output bit ack);
    i2c_start();
    wr_byte({7'b1010000, rd}, ack);
  endtask

  task automatic poll_ready();
    bit ack;
    for (int k = 0; k < 60; k++) begin
      dev_open(1'b0, ack);
      i2c_stop();
      if (ack) break;
    end
  endtask

  task automatic page_write(input logic [7:0] a0, input int n);
    bit ack;
    poll_ready();
    dev_open(1'b0, ack);
    chk("R2", "write device byte ack", 32'(ack), 32'd1);
    wr_byte(a0, ack);
    chk("R4", "word address ack", 32'(ack), 32'd1);
    for (int i = 0; i < n; i++) begin
      wr_byte(wbuf[i], ack);
      chk("R6", "data byte ack", 32'(ack), 32'd1);
      ref_mem[{a0[7:4], a0[3:0] + 4'(i)}] = wbuf[i];
    end
    i2c_stop();
    ref_addr = a0;
  endtask

  task automatic rand_read(input logic [7:0] a, input int n);
    bit ack;
    logic [7:0] d;
    poll_ready();
    dev_open(1'b0, ack);
    wr_byte(a, ack);
    i2c_start();
    wr_byte(8'hA1, ack);
    chk("R9", "read device byte ack after repeated start", 32'(ack), 32'd1);
    for (int i = 0; i < n; i++) begin
      rd_byte(i != n - 1, d);
      chk("R10", $sformatf("read byte at %0h", 8'(a + 8'(i))), 32'(d), 32'(ref_mem[8'(a + 8'(i))]));
    end
    i2c_stop();
    ref_addr = 8'(a + 8'(n));
  endtask

  task automatic cur_read(input int n);
    bit ack;
    logic [7:0] d;
    poll_ready();
    dev_open(1'b1, ack);
    chk("R8", "current read ack", 32'(ack), 32'd1);
    for (int i = 0; i < n; i++) begin
      rd_byte(i != n - 1, d);
      chk("R8", $sformatf("current read at %0h", 8'(ref_addr + 8'(i))), 32'(d), 32'(ref_mem[8'(ref_addr + 8'(i))]));
    end
    i2c_stop();
    ref_addr = 8'(ref_addr + 8'(n));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] a, d, old, bad;
    int n, c0, s0, ab0;
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'hFF;
      ref_mem[i] = 8'hFF;
    end
    ref_addr = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    chk("R1", "released after reset", 32'(sda_oe), 32'd0);

    // no START: a matching byte is ignored
    wr_byte(8'hA0, ack);
    chk("R1", "no ack without start", 32'(ack), 32'd0);
    chk("R1", "no load without start", 32'(n_load), 32'd0);
    i2c_stop();

    // wrong device identity
    for (int k = 0; k < 3; k++) begin
      bad = 8'($urandom);
      if (bad[7:1] == 7'b1010000) bad[1] = ~bad[1];
      i2c_start();
      wr_byte(bad, ack);
      chk("R2", "no ack for foreign address", 32'(ack), 32'd0);
      i2c_stop();
    end

    // byte write
    a = 8'($urandom);
    wbuf[0] = 8'($urandom);
    c0 = n_commit;
    page_write(a, 1);
    chk("R6", "one commit after stop", 32'(n_commit), 32'(c0 + 1));

    // busy: own address refused (ack polling)
    dev_open(1'b0, ack);
    chk("R5", "no ack while busy", 32'(ack), 32'd0);
    i2c_stop();

    rand_read(a, 1);
    cur_read(2);

    // random page writes with full page readback
    for (int k = 0; k < 4; k++) begin
      a = 8'($urandom);
      n = 1 + int'($urandom % 20);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      page_write(a, n);
      rand_read({a[7:4], 4'h0}, 16);
    end

    // wrap at end of memory, then continue from 02
    rand_read(8'hFE, 4);
    cur_read(1);

    // write protect high before the first data byte
    poll_ready();
    a = 8'($urandom);
    ab0 = n_abort;
    s0 = n_strobe;
    c0 = n_commit;
    wp = 1'b1;
    dev_open(1'b0, ack);
    wr_byte(a, ack);
    chk("R7", "address still acked under protect", 32'(ack), 32'd1);
    wr_byte(~ref_mem[a], ack);
    chk("R7", "first data byte refused", 32'(ack), 32'd0);
    i2c_stop();
    wp = 1'b0;
    chk("R7", "abort pulse", 32'(n_abort), 32'(ab0 + 1));
    chk("R7", "no strobe", 32'(n_strobe), 32'(s0));
    chk("R7", "no commit", 32'(n_commit), 32'(c0));
    dev_open(1'b0, ack);
    chk("R7", "not busy after rejected write", 32'(ack), 32'd1);
    i2c_stop();
    rand_read(a, 1);

    // write protect rising after the first data byte has no effect
    a = 8'($urandom);
    wbuf[0] = 8'($urandom);
    wbuf[1] = 8'($urandom);
    poll_ready();
    dev_open(1'b0, ack);
    wr_byte(a, ack);
    wr_byte(wbuf[0], ack);
    chk("R7", "first data ack with protect low", 32'(ack), 32'd1);
    wp = 1'b1;
    wr_byte(wbuf[1], ack);
    chk("R7", "later protect ignored", 32'(ack), 32'd1);
    i2c_stop();
    wp = 1'b0;
    ref_mem[a] = wbuf[0];
    ref_mem[{a[7:4], a[3:0] + 4'd1}] = wbuf[1];
    rand_read({a[7:4], 4'h0}, 16);

    // repeated START after stored data: discard, read old value
    poll_ready();
    a = 8'($urandom);
    old = ref_mem[a];
    ab0 = n_abort;
    c0 = n_commit;
    dev_open(1'b0, ack);
    wr_byte(a, ack);
    wr_byte(~old, ack);
    i2c_start();
    wr_byte(8'hA1, ack);
    chk("R11", "ack after repeated start, nothing committed", 32'(ack), 32'd1);
    rd_byte(1'b0, d);
    i2c_stop();
    chk("R11", "data not written", 32'(d), 32'(old));
    chk("R11", "abort on repeated start", 32'(n_abort), 32'(ab0 + 1));
    chk("R11", "no commit", 32'(n_commit), 32'(c0));
    ref_addr = 8'(a + 8'd1);

    // STOP in the middle of a byte
    i2c_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    i2c_stop();
    chk("R11", "released after mid-byte stop", 32'(sda_oe), 32'd0);
    cur_read(1);

    chk("R12", "no overlapping commands", 32'(n_overlap), 32'd0);
    chk("R3", "no line change while clock high", 32'(n_oe_bad), 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule